// File: doc/BRIEF.md
# Floppy Controller Command-Phase Sequencer

This block is the byte-wide host side of a floppy disk controller. A host reaches it through a small eight-location I/O window that holds four things. A status byte tells the host whether it may write, must read, or must wait. A data port carries command bytes in and result and sector bytes out. A control register holds the DMA enable. The block walks each command through three phases. It collects the command bytes, runs the command, and then offers a block of result bytes. It raises its interrupt while the results wait to be read.

There are two read-style commands, full sector read and sector verify, and a header read command. With DMA turned off, a sector read streams every byte of the chosen sectors out through the data port. Those bytes come from a simple sector-data source. The source shows one byte at a time and receives a take strobe for each byte the host reads. The header read waits a fixed number of cycles before its results appear. This wait stands in for the time the head needs to find a sector header. Any opcode the block does not know gets a single error byte back.

Top module: `fdcq_top`

## Requirements
- R1: After reset the status byte (address 4) reads 0x80 and irq is low. Once the first command byte is accepted and more are expected, the status byte reads 0x90. In the status byte, bit 7 is ready, bit 6 is direction (1 = controller to host), bit 5 is non-DMA transfer and bit 4 is busy.
- R2: Only the low five bits of the opcode select the command: 0x06 is sector read, 0x16 is verify, 0x0A is header read. The upper three bits are ignored. Read and verify take 9 bytes in this order: opcode, drive/head (head in bit 2, drive in bits 1:0), cylinder, head, first sector, size code, last sector, gap, data length. Header read takes 2 bytes: opcode and drive/head.
- R3: A verify, or a read with DMA enabled, goes straight to the result phase after its ninth byte. The status byte then reads 0xD0 and irq is high. The result is 7 bytes: ST0, 0, 0, cylinder, head, last sector reached, size code.
- R4: A read with DMA disabled shows status 0xF0 while data is pending. It delivers 512 bytes per sector, for every sector from the first sector through the capped last sector. Each byte comes from the source value on srcData, and srcTake pulses once for each byte read. After the final data byte the 7-byte result follows.
- R5: irq is high for the whole result phase of read, verify and header read, and low at all other times. It falls on the edge that consumes the seventh result byte. After that the status byte reads 0x80.
- R6: If the last sector is above 18, the transfer stops at sector 18, ST0 is 0x20 and the reported last sector is 18. Otherwise ST0 is 0x04. If the first sector is past the capped last sector, no data is sent and the result phase follows at once.
- R7: A header read shows status 0x10 for ID_DELAY cycles and then enters the result phase. Its result is: drive/head bits 2:0 as ST0, 0, 0, the cylinder given to the most recent read or verify, the head bit, 1, 2.
- R8: An unknown opcode gives a one-byte result of 0x80 with status 0xD0 and irq low. Reading that byte brings the status back to 0x80.
- R9: A data-port write while the direction bit is 1 is ignored. A data-port read in the command phase returns 0 and changes nothing.
- R10: Address 2 is the control register, which reads back its last written value. It resets to 0x08, and bit 3 set means DMA is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address within the I/O window |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| rdEn | input | 1 | Read strobe, one cycle per byte (pops the data port) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt, high during the result phase of read, verify and header read |
| srcData | input | 8 | Current byte from the sector-data source |
| srcTake | output | 1 | Pulses when the host consumes the current source byte |

## Verification
If the phase state goes wrong, the status byte is wrong on the very next read. For example, a transfer counter that stops too soon or too late moves the 0xF0 to 0xD0 change and the irq rise by at least one data byte. The bench compares irq against its model on every clock and checks every data byte. So a count error of a single byte shows up as a data or level mismatch within one host access. Retained command bytes that are latched wrongly appear in the result bytes, including the cylinder that a later header read reports.

// File: rtl/fdcq_pkg.sv
package fdcq_pkg;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_WAIT, PH_RES} phase_e;
  typedef enum logic [1:0] {K_READ, K_VERIFY, K_RDID, K_BAD} kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capArg;
    logic startXfer;
    logic stepXfer;
    logic startTimer;
    logic stepTimer;
  } ctl_t;

  localparam logic [4:0] OP_READ   = 5'h06;
  localparam logic [4:0] OP_VERIFY = 5'h16;
  localparam logic [4:0] OP_RDID   = 5'h0A;

  function automatic kind_e decodeOp(input logic [4:0] op);
    case (op)
      OP_READ:   return K_READ;
      OP_VERIFY: return K_VERIFY;
      OP_RDID:   return K_RDID;
      default:   return K_BAD;
    endcase
  endfunction

endpackage

// File: rtl/fdcq_datapath.sv
module fdcq_datapath
  import fdcq_pkg::*;
#(
  parameter int SPT          = 18,
  parameter int SECTOR_BYTES = 512,
  parameter int ID_DELAY     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_t       ctl,
  input  logic [3:0] argIdx,
  input  logic [7:0] wdata,
  input  kind_e      kind,
  input  logic [2:0] resIdx,
  output logic [7:0] resByte,
  output logic       xferEmpty,
  output logic       xferLast,
  output logic       timerDone
);
  localparam int CNT_W = $clog2((SPT + 1) * SECTOR_BYTES + 1);
  localparam int TMR_W = $clog2(ID_DELAY + 1);
  localparam int N_ARG = 9;

  logic [7:0] argReg [N_ARG];
  logic [CNT_W-1:0] xferCnt, xferTotal;
  logic [TMR_W-1:0] timer;
  logic [7:0] lastSec, nSect;
  logic       overrun;

  // argument capture, one register per command byte position
  for (genvar g = 1; g < N_ARG; g++) begin : g_arg
    always_ff @(posedge clk) begin
      if (!rstN)                                argReg[g] <= '0;
      else if (ctl.capArg && argIdx == 4'(g))   argReg[g] <= wdata;
    end
  end
  assign argReg[0] = '0;

  assign overrun   = argReg[6] > 8'(SPT);
  assign lastSec   = overrun ? 8'(SPT) : argReg[6];
  assign nSect     = (lastSec >= argReg[4]) ? (lastSec - argReg[4] + 8'd1) : 8'd0;
  assign xferTotal = CNT_W'(nSect) * CNT_W'(SECTOR_BYTES);
  assign xferEmpty = (nSect == 8'd0);
  assign xferLast  = (xferCnt == CNT_W'(1));
  assign timerDone = (timer == TMR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferCnt <= '0;
      timer   <= '0;
    end else begin
      if (ctl.startXfer)      xferCnt <= xferTotal;
      else if (ctl.stepXfer)  xferCnt <= xferCnt - CNT_W'(1);
      if (ctl.startTimer)     timer <= TMR_W'(ID_DELAY);
      else if (ctl.stepTimer) timer <= timer - TMR_W'(1);
    end
  end

  always_comb begin
    resByte = 8'h00;
    case (kind)
      K_BAD: resByte = 8'h80;
      K_RDID:
        case (resIdx)
          3'd0:    resByte = {5'b0, argReg[1][2:0]};
          3'd3:    resByte = argReg[2];
          3'd4:    resByte = {7'b0, argReg[1][2]};
          3'd5:    resByte = 8'd1;
          3'd6:    resByte = 8'd2;
          default: resByte = 8'h00;
        endcase
      default:
        case (resIdx)
          3'd0:    resByte = overrun ? 8'h20 : 8'h04;
          3'd3:    resByte = argReg[2];
          3'd4:    resByte = argReg[3];
          3'd5:    resByte = lastSec;
          3'd6:    resByte = argReg[5];
          default: resByte = 8'h00;
        endcase
    endcase
  end

endmodule

// File: rtl/fdcq_ctrl.sv
module fdcq_ctrl
  import fdcq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoWr,
  input  logic       fifoRd,
  input  logic [4:0] opLow,
  input  logic       dmaOn,
  input  logic       xferEmpty,
  input  logic       xferLast,
  input  logic       timerDone,
  output phase_e     phase,
  output kind_e      kind,
  output logic [3:0] argIdx,
  output logic [2:0] resIdx,
  output ctl_t       ctl
);
  kind_e      newKind;
  logic [3:0] lastArgIdx;
  logic [2:0] lastRes;
  logic       lastArg;

  assign newKind    = decodeOp(opLow);
  assign lastArgIdx = (kind == K_RDID) ? 4'd1 : 4'd8;
  assign lastArg    = (argIdx == lastArgIdx);
  assign lastRes    = (kind == K_BAD) ? 3'd0 : 3'd6;

  always_comb begin
    ctl            = '0;
    ctl.capArg     = (phase == PH_CMD) && fifoWr && (argIdx != 4'd0);
    ctl.startXfer  = ctl.capArg && lastArg && (kind == K_READ) && !dmaOn;
    ctl.startTimer = ctl.capArg && lastArg && (kind == K_RDID);
    ctl.stepXfer   = (phase == PH_DATA) && fifoRd;
    ctl.stepTimer  = (phase == PH_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_CMD;
      kind   <= K_BAD;
      argIdx <= '0;
      resIdx <= '0;
    end else begin
      case (phase)
        PH_CMD:
          if (fifoWr) begin
            if (argIdx == 4'd0) begin
              kind   <= newKind;
              resIdx <= '0;
              if (newKind == K_BAD) phase <= PH_RES;
              else                  argIdx <= 4'd1;
            end else if (lastArg) begin
              argIdx <= '0;
              if (kind == K_RDID)                              phase <= PH_WAIT;
              else if (kind == K_READ && !dmaOn && !xferEmpty) phase <= PH_DATA;
              else                                             phase <= PH_RES;
            end else begin
              argIdx <= argIdx + 4'd1;
            end
          end
        PH_DATA: if (fifoRd && xferLast) phase <= PH_RES;
        PH_WAIT: if (timerDone)          phase <= PH_RES;
        PH_RES:
          if (fifoRd) begin
            if (resIdx == lastRes) begin
              phase  <= PH_CMD;
              resIdx <= '0;
            end else begin
              resIdx <= resIdx + 3'd1;
            end
          end
        default: phase <= PH_CMD;
      endcase
    end
  end

endmodule

// File: rtl/fdcq_top.sv
module fdcq_top
  import fdcq_pkg::*;
#(
  parameter int SPT          = 18,
  parameter int SECTOR_BYTES = 512,
  parameter int ID_DELAY     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic [7:0] srcData,
  output logic       srcTake
);
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;

  phase_e     phase;
  kind_e      kind;
  ctl_t       ctl;
  logic [3:0] argIdx;
  logic [2:0] resIdx;
  logic [7:0] resByte, ctrlReg, msrVal;
  logic       fifoWr, fifoRd, xferEmpty, xferLast, timerDone;

  assign fifoWr = wrEn && (addr == A_DATA);
  assign fifoRd = rdEn && (addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rstN)                          ctrlReg <= 8'h08;
    else if (wrEn && addr == A_CTRL)    ctrlReg <= wdata;
  end

  fdcq_ctrl u_ctrl (
    .clk, .rstN, .fifoWr, .fifoRd, .opLow(wdata[4:0]), .dmaOn(ctrlReg[3]),
    .xferEmpty, .xferLast, .timerDone, .phase, .kind, .argIdx, .resIdx, .ctl
  );

  fdcq_datapath #(.SPT(SPT), .SECTOR_BYTES(SECTOR_BYTES), .ID_DELAY(ID_DELAY)) u_dp (
    .clk, .rstN, .ctl, .argIdx, .wdata, .kind, .resIdx, .resByte,
    .xferEmpty, .xferLast, .timerDone
  );

  always_comb begin
    case (phase)
      PH_CMD:  msrVal = (argIdx != 4'd0) ? 8'h90 : 8'h80;
      PH_DATA: msrVal = 8'hF0;
      PH_WAIT: msrVal = 8'h10;
      default: msrVal = 8'hD0;
    endcase
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrlReg;
      A_STAT:  rdata = msrVal;
      A_DATA:  rdata = (phase == PH_DATA) ? srcData :
                       (phase == PH_RES)  ? resByte : 8'h00;
      default: rdata = 8'h00;
    endcase
  end

  assign irq     = (phase == PH_RES) && (kind != K_BAD);
  assign srcTake = fifoRd && (phase == PH_DATA);

endmodule

// File: rtl/fdcq_chk.sv
module fdcq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] addr,
  input logic       wrEn,
  input logic       rdEn,
  input logic       irq,
  input logic       srcTake,
  input logic [7:0] msrVal
);
  // R5
  irq_in_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> msrVal == 8'hD0);
  // R5
  irq_drop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> msrVal == 8'h80);
  // R4
  take_in_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcTake |-> (msrVal == 8'hF0 && !irq));
  // R9
  wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd5 && msrVal[6] && !rdEn) |=> $stable(msrVal));
  // R7
  wait_busy_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !msrVal[7] |-> msrVal == 8'h10);
endmodule

bind fdcq_top fdcq_chk chk_i (
  .clk, .rstN, .addr, .wrEn, .rdEn, .irq, .srcTake, .msrVal
);

// File: tb/fdcq_tb.sv
module fdcq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_DELAY   = 16;
  localparam int SPT        = 18;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, srcData;
  logic       irq, srcTake;

  int   nChecks = 0, nFail = 0;
  logic expIrq = 1'b0;
  logic running = 1'b0;
  logic [7:0] ctrlShadow = 8'h08;
  logic [15:0] srcIdx = '0;
  int   srcK = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdcq_top #(.ID_DELAY(ID_DELAY)) dut_i (
    .clk, .rstN, .addr, .wrEn, .rdEn, .wdata, .rdata, .irq, .srcData, .srcTake
  );

  // sector-data source model
  always @(posedge clk) if (srcTake) srcIdx <= srcIdx + 16'd1;
  assign srcData = srcIdx[7:0] ^ srcIdx[15:8] ^ 8'h5A;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of interrupt against model
  always @(negedge clk) if (running) chk("R5 irq level", irq, expIrq);

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wrEn = 1'b1;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rdEn = 1'b0;
  endtask

  task automatic peekMsr(output logic [7:0] m);
    addr = 3'd4; #1 m = rdata;
  endtask

  task automatic readResult(input string tag, input int n, input logic [55:0] exp);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      busRead(3'd5, b);
      chk({tag, " result byte"}, b, exp[55-8*i -: 8]);
      if (i == n-1) expIrq = 1'b0;
    end
    peekMsr(b);
    chk("R5 status after result", b, 8'h80);
  endtask

  task automatic runRead(input logic [7:0] op, dh, cyl, hd, sec, sz, eot);
    logic [7:0] m, b, lastS, st0;
    int nS;
    logic isRead;
    isRead = (op[4:0] == 5'h06);
    lastS  = (eot > 8'(SPT)) ? 8'(SPT) : eot;
    st0    = (eot > 8'(SPT)) ? 8'h20 : 8'h04;
    nS     = (lastS >= sec) ? int'(lastS - sec) + 1 : 0;
    busWrite(3'd5, op);
    peekMsr(m); chk("R1 busy after opcode", m, 8'h90);
    busWrite(3'd5, dh);  busWrite(3'd5, cyl); busWrite(3'd5, hd);
    busWrite(3'd5, sec); busWrite(3'd5, sz);  busWrite(3'd5, eot);
    busWrite(3'd5, 8'h1B);
    busWrite(3'd5, 8'hFF);
    if (isRead && !ctrlShadow[3] && nS > 0) begin
      peekMsr(m); chk("R4 status in data", m, 8'hF0);
      for (int j = 0; j < nS * 512; j++) begin
        busRead(3'd5, b);
        chk("R4 data byte", b, srcK[7:0] ^ srcK[15:8] ^ 8'h5A);
        srcK++;
        if (j == 0) begin
          busWrite(3'd5, 8'h55);
          peekMsr(m); chk("R9 write in data ignored", m, 8'hF0);
        end
      end
      chk("R4 take count", 32'(srcIdx), 32'(srcK));
    end
    expIrq = 1'b1;
    peekMsr(m); chk("R3 status in result", m, 8'hD0);
    busWrite(3'd5, 8'h55);
    peekMsr(m); chk("R9 write in result ignored", m, 8'hD0);
    readResult(st0 == 8'h20 ? "R6" : "R3", 7, {st0, 8'h00, 8'h00, cyl, hd, lastS, sz});
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (ID_DELAY * 0 + 200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] m, b;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    running = 1'b1;
    @(posedge clk); #1;

    // R1 reset state, R10 control default
    peekMsr(m); chk("R1 reset status", m, 8'h80);
    busRead(3'd2, b); chk("R10 control reset", b, 8'h08);

    // R9 read of data port in command phase
    busRead(3'd5, b); chk("R9 cmd-phase read", b, 8'h00);
    peekMsr(m); chk("R9 status unchanged", m, 8'h80);

    // R2 upper opcode bits ignored, R3 DMA read
    runRead(8'hE6, 8'h04, 8'h03, 8'h01, 8'h01, 8'h02, 8'h01);

    // R6 verify with last sector past track end
    runRead(8'h16, 8'h00, 8'h07, 8'h00, 8'h05, 8'h02, 8'h13);

    // R8 unknown opcode
    busWrite(3'd5, 8'h1F);
    peekMsr(m); chk("R8 status after bad opcode", m, 8'hD0);
    busRead(3'd5, b); chk("R8 invalid byte", b, 8'h80);
    peekMsr(m); chk("R8 status back to idle", m, 8'h80);

    // R7 header read, R2 with flag bits set
    busWrite(3'd5, 8'h4A);
    peekMsr(m); chk("R7 busy after opcode", m, 8'h90);
    busWrite(3'd5, 8'h05);
    peekMsr(m); chk("R7 waiting status", m, 8'h10);
    repeat (ID_DELAY - 1) @(posedge clk);
    #1 peekMsr(m); chk("R7 still waiting", m, 8'h10);
    @(posedge clk); #1 expIrq = 1'b1;
    peekMsr(m); chk("R7 status in result", m, 8'hD0);
    readResult("R7", 7, {8'h05, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h02});

    // R10 disable DMA
    busWrite(3'd2, 8'h00); ctrlShadow = 8'h00;
    busRead(3'd2, b); chk("R10 control readback", b, 8'h00);

    // R4 one sector non-DMA
    runRead(8'h06, 8'h00, 8'h02, 8'h00, 8'h01, 8'h02, 8'h01);
    // R6 capped two-sector non-DMA
    runRead(8'h06, 8'h04, 8'h04, 8'h01, 8'h11, 8'h02, 8'h13);
    // R6 empty range goes straight to result
    runRead(8'hC6, 8'h00, 8'h09, 8'h00, 8'h05, 8'h02, 8'h03);

    running = 1'b0;
    finishRun();
  end

endmodule